// File: doc/BRIEF.md
# Pipeline Front-End Fetch and Branch Controller

This block is the front end of a small in-order five-stage pipeline for a reduced 32-bit load/store instruction set. It owns the program counter and one nop bit per stage (fetch, decode, execute, memory, writeback). A nop bit set to 1 marks that stage as idle for the cycle. Each cycle the block reads four instruction bytes, one lane per byte, from a byte-addressed instruction memory starting at the PC. It assembles them big-endian and hands the word to decode together with the PC it came from.

Branches are predicted not taken. A not-equal branch is resolved in decode using the two register values that the decode logic supplies. When the branch is taken, the instruction fetched behind it is squashed and fetch is redirected. A halt instruction is detected at fetch and never enters decode. From that point the nop bits turn to 1 stage by stage, and a registered done flag goes high once the whole pipe is idle. A hazard unit can freeze fetch and decode with a stall input. While stalled, a bubble is injected into execute.

Top module: `fetch_branch_ctl`

## Requirements
- R1: During and straight after reset the PC is 0, the fetch nop bit is 0, the decode, execute, memory and writeback nop bits are 1, and done is 0.
- R2: The byte on lane k (bits 8k+7:8k of the lane input) is the memory byte at PC+k. The lane 0 byte becomes bits 31:24 of the decode instruction, lane 1 bits 23:16, lane 2 bits 15:8 and lane 3 bits 7:0.
- R3: With no stall, the execute, memory and writeback nop bits each take, one cycle later, the nop bit the stage before them held.
- R4: Each normal fetch advances the PC by 4, including when the fetched word is a branch.
- R5: A valid decode instruction with opcode 000101 in bits 31:26 is taken when the two register values differ. The next PC is then the branch's own PC + 4 + (sign-extended bits 15:0 shifted left by 2). Negative offsets are included.
- R6: On a taken branch, the instruction fetched in the same cycle is squashed: the decode nop bit is 1 in the next cycle.
- R7: When the two register values are equal, the branch is not taken and fetch carries on sequentially.
- R8: A fetched word with opcode 111111 in bits 31:26 (halt) sets the fetch and decode nop bits to 1 in the next cycle, and both stay 1. The PC holds. Execute, memory and writeback become idle one, two and three cycles after that.
- R9: A halt fetched in the same cycle that a taken branch is resolved in decode is discarded and does not stop fetch.
- R10: While the stall input is 1, the PC and the decode instruction hold, and the execute nop bit is 1 in the next cycle.
- R11: Done rises one cycle after a cycle in which all five nop bits are 1, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| imem_addr_o | output | 32 | Fetch address (current PC) |
| imem_lanes_i | input | 32 | Four instruction bytes; lane k is the byte at address PC+k |
| rs_val_i | input | 32 | First register operand read by decode |
| rt_val_i | input | 32 | Second register operand read by decode |
| stall_i | input | 1 | Hold fetch and decode, inject an execute bubble |
| id_instr_o | output | 32 | Instruction held in the decode stage |
| id_pc_o | output | 32 | PC of the instruction held in decode |
| stage_nop_o | output | 5 | Nop bits: bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback |
| done_o | output | 1 | Registered, sticky pipeline-empty flag |

## Verification
The embedded properties watch, on every cycle, the shift of nop bits through the later stages, the stickiness of the fetch idle bit after halt, squashing after a taken branch, the freeze and bubble under stall, and the stickiness and consistency of done. Other behaviours depend on the instruction stream, so only the directed programs show them. These are the big-endian byte order, the exact branch target for positive and negative offsets, the not-taken path, the halt cascade timing, and a halt discarded behind a taken branch.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_HALT = 6'b111111;
  localparam int NSTAGE = 5;

  typedef enum logic [2:0] {
    STG_IF  = 3'd0,
    STG_ID  = 3'd1,
    STG_EX  = 3'd2,
    STG_MEM = 3'd3,
    STG_WB  = 3'd4
  } stage_e;
endpackage

// File: rtl/fbc_branch.sv
module fbc_branch
  import fbc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  target_o
);
  localparam int NBYTES = XLEN / BYTE_W;
  localparam int SHAMT  = 2;

  logic [XLEN-1:0] offset;

  always_comb begin
    offset   = {{(XLEN-IMM_W-SHAMT){imm_i[IMM_W-1]}}, imm_i, {SHAMT{1'b0}}};
    target_o = pc_i + XLEN'(NBYTES) + offset;
    taken_o  = valid_i && (opcode_i == OPC_BNE) && (rs_i != rt_i);
  end
endmodule

// File: rtl/fbc_fetch.sv
module fbc_fetch
  import fbc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] lanes_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] id_instr_o,
  output logic [XLEN-1:0] id_pc_o,
  output logic            if_nop_o,
  output logic            id_nop_o
);
  localparam int NBYTES = XLEN / BYTE_W;

  logic [XLEN-1:0] word;
  logic [XLEN-1:0] pc_q, pc_d, id_instr_q, id_pc_q;
  logic            if_nop_q, if_nop_d, id_nop_q, id_nop_d;
  logic            pc_en, id_load, fetch_halt;

  // big-endian assembly: lane 0 lands in the top byte
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign word[XLEN-1-k*BYTE_W -: BYTE_W] = lanes_i[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    fetch_halt = !if_nop_q && (word[XLEN-1 -: OPC_W] == OPC_HALT);
    pc_en      = 1'b0;
    pc_d       = pc_q;
    id_load    = 1'b0;
    if_nop_d   = if_nop_q;
    id_nop_d   = id_nop_q;
    if (!stall_i) begin
      if (taken_i) begin
        pc_en    = 1'b1;
        pc_d     = target_i;
        id_nop_d = 1'b1;
      end else if (if_nop_q) begin
        id_nop_d = 1'b1;
      end else if (fetch_halt) begin
        if_nop_d = 1'b1;
        id_nop_d = 1'b1;
      end else begin
        pc_en    = 1'b1;
        pc_d     = pc_q + XLEN'(NBYTES);
        id_load  = 1'b1;
        id_nop_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      if_nop_q   <= 1'b0;
      id_nop_q   <= 1'b1;
      id_instr_q <= '0;
      id_pc_q    <= RESET_PC;
    end else begin
      if_nop_q <= if_nop_d;
      id_nop_q <= id_nop_d;
      if (pc_en) pc_q <= pc_d;
      if (id_load) begin
        id_instr_q <= word;
        id_pc_q    <= pc_q;
      end
    end
  end

  assign pc_o       = pc_q;
  assign id_instr_o = id_instr_q;
  assign id_pc_o    = id_pc_q;
  assign if_nop_o   = if_nop_q;
  assign id_nop_o   = id_nop_q;

  // R8
  if_idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_nop_q |=> if_nop_q);
  // R6
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_i && !stall_i) |=> id_nop_q);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(pc_q) && $stable(id_instr_q)));
endmodule

// File: rtl/fbc_nop_pipe.sv
module fbc_nop_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_i,
  output logic [DEPTH-1:0] nop_o
);
  logic [DEPTH-1:0] nop_q, nop_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      assign nop_d[i] = head_i;
    end else begin : g_body
      assign nop_d[i] = nop_q[i-1];
      // R3
      nop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (nop_q[i] == $past(nop_q[i-1])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nop_q[i] <= 1'b1;
      else        nop_q[i] <= nop_d[i];
    end
  end

  assign nop_o = nop_q;
endmodule

// File: rtl/fetch_branch_ctl.sv
module fetch_branch_ctl
  import fbc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              IMM_W    = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr_o,
  input  logic [XLEN-1:0]   imem_lanes_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic              stall_i,
  output logic [XLEN-1:0]   id_instr_o,
  output logic [XLEN-1:0]   id_pc_o,
  output logic [NSTAGE-1:0] stage_nop_o,
  output logic              done_o
);
  localparam int TAIL = NSTAGE - 2;

  logic            taken, if_nop, id_nop, ex_head;
  logic [XLEN-1:0] target;
  logic [TAIL-1:0] tail_nop;
  logic            done_q, done_d;

  fbc_fetch #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .taken_i    (taken),
    .target_i   (target),
    .lanes_i    (imem_lanes_i),
    .pc_o       (imem_addr_o),
    .id_instr_o (id_instr_o),
    .id_pc_o    (id_pc_o),
    .if_nop_o   (if_nop),
    .id_nop_o   (id_nop)
  );

  fbc_branch #(.XLEN(XLEN), .IMM_W(IMM_W)) u_branch (
    .valid_i  (!id_nop),
    .opcode_i (id_instr_o[XLEN-1 -: OPC_W]),
    .imm_i    (id_instr_o[IMM_W-1:0]),
    .pc_i     (id_pc_o),
    .rs_i     (rs_val_i),
    .rt_i     (rt_val_i),
    .taken_o  (taken),
    .target_o (target)
  );

  assign ex_head = stall_i | id_nop;

  fbc_nop_pipe #(.DEPTH(TAIL)) u_tail (
    .clk    (clk),
    .rst_n  (rst_n),
    .head_i (ex_head),
    .nop_o  (tail_nop)
  );

  assign stage_nop_o = {tail_nop, id_nop, if_nop};

  always_comb done_d = done_q | (&stage_nop_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done_o = done_q;

  // R10
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> stage_nop_o[STG_EX]);
  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (&stage_nop_o));
endmodule

// File: tb/fetch_branch_ctl_tb_top.sv
`timescale 1ns/1ps
module fetch_branch_ctl_tb_top;
  localparam int  MEMSZ = 64;
  localparam real HALF  = 2.5;
  localparam int  WD_CYC = 200000;

  typedef struct {
    int          cyc;
    logic [31:0] pc;
    logic [4:0]  nop;
    logic        done;
    logic        chk_instr;
    logic [31:0] instr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, lanes, rs_val, rt_val, id_instr, id_pc;
  logic        stall;
  logic [4:0]  stage_nop;
  logic        done;
  logic [7:0]  mem [MEMSZ];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  exp_t        exp_q[$];
  exp_t        cur;

  localparam logic [31:0] W0   = 32'h00A2_B4C6;
  localparam logic [31:0] W1   = 32'h01E3_F521;
  localparam logic [31:0] HALT = 32'hFC00_0000;

  always #HALF clk = ~clk;

  fetch_branch_ctl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_lanes_i (lanes),
    .rs_val_i     (rs_val),
    .rt_val_i     (rt_val),
    .stall_i      (stall),
    .id_instr_o   (id_instr),
    .id_pc_o      (id_pc),
    .stage_nop_o  (stage_nop),
    .done_o       (done)
  );

  always_comb begin
    for (int k = 0; k < 4; k++)
      lanes[8*k +: 8] = mem[6'(imem_addr + 32'(k))];
  end

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic logic [31:0] bne_w(input logic [15:0] imm);
    return {6'b000101, 5'd1, 5'd2, imm};
  endfunction

  task automatic put_word(input int a, input logic [31:0] w);
    mem[a]   = w[31:24];
    mem[a+1] = w[23:16];
    mem[a+2] = w[15:8];
    mem[a+3] = w[7:0];
  endtask

  task automatic expect_st(input int c, input logic [31:0] pc, input logic [4:0] nop,
                           input logic dn, input logic ci, input logic [31:0] ins,
                           input string tag);
    exp_t e;
    e.cyc = c; e.pc = pc; e.nop = nop; e.done = dn;
    e.chk_instr = ci; e.instr = ins; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp_v);
    end
  endtask

  // monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
      cur = exp_q.pop_front();
      check(imem_addr === cur.pc, cur.tag, "pc", imem_addr, cur.pc);
      check(stage_nop === cur.nop, cur.tag, "nop", 32'(stage_nop), 32'(cur.nop));
      check(done === cur.done, cur.tag, "done", 32'(done), 32'(cur.done));
      if (cur.chk_instr)
        check(id_instr === cur.instr, cur.tag, "instr", id_instr, cur.instr);
    end
  end

  task automatic begin_scn(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    rst_n = 1'b0;
    stall = 1'b0;
    rs_val = a;
    rt_val = b;
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    @(posedge clk);
    #1;
  endtask

  task automatic release_run(input int n);
    @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (n) @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      check(1'b0, cur.tag, "missed cycle", 32'(cyc), 32'(cur.cyc));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // A: straight line then halt (R1 R2 R3 R4 R8 R11)
    begin_scn(32'd0, 32'd0);
    put_word(0, W0); put_word(4, W1); put_word(8, HALT);
    expect_st(0, 32'd0, 5'b11110, 1'b0, 1'b0, 32'd0, "R1 reset state");
    expect_st(1, 32'd4, 5'b11100, 1'b0, 1'b1, W0,    "R2 R4 first fetch");
    expect_st(2, 32'd8, 5'b11000, 1'b0, 1'b1, W1,    "R3 R4 second fetch");
    expect_st(3, 32'd8, 5'b10011, 1'b0, 1'b0, 32'd0, "R8 halt front idle");
    expect_st(4, 32'd8, 5'b00111, 1'b0, 1'b0, 32'd0, "R8 R3 ex idle");
    expect_st(5, 32'd8, 5'b01111, 1'b0, 1'b0, 32'd0, "R8 mem idle");
    expect_st(6, 32'd8, 5'b11111, 1'b0, 1'b0, 32'd0, "R11 all idle no done yet");
    expect_st(7, 32'd8, 5'b11111, 1'b1, 1'b0, 32'd0, "R11 done rises");
    expect_st(9, 32'd8, 5'b11111, 1'b1, 1'b0, 32'd0, "R11 done sticky");
    release_run(10);

    // B: taken branch, halt on wrong path (R5 R6 R9 R1)
    begin_scn(32'd1, 32'd2);
    put_word(0, bne_w(16'd3)); put_word(4, HALT);
    put_word(16, W1); put_word(20, HALT);
    expect_st(0, 32'd0,  5'b11110, 1'b0, 1'b0, 32'd0, "R1 reset after done");
    expect_st(1, 32'd4,  5'b11100, 1'b0, 1'b1, bne_w(16'd3), "R4 pc+4 past branch");
    expect_st(2, 32'd16, 5'b11010, 1'b0, 1'b0, 32'd0, "R5 R6 R9 taken redirect");
    expect_st(3, 32'd20, 5'b10100, 1'b0, 1'b1, W1,    "R3 R5 target fetched");
    expect_st(4, 32'd20, 5'b01011, 1'b0, 1'b0, 32'd0, "R8 halt at target");
    release_run(6);

    // C: branch not taken (R7)
    begin_scn(32'd7, 32'd7);
    put_word(0, bne_w(16'd3)); put_word(4, W1);
    expect_st(2, 32'd8, 5'b11000, 1'b0, 1'b1, W1, "R7 not taken sequential");
    release_run(4);

    // D: backward branch with negative offset (R5)
    begin_scn(32'd3, 32'd4);
    put_word(0, W0); put_word(4, W1); put_word(8, bne_w(16'hFFFD));
    expect_st(3, 32'd12, 5'b10000, 1'b0, 1'b1, bne_w(16'hFFFD), "R5 branch in decode");
    expect_st(4, 32'd0,  5'b00010, 1'b0, 1'b0, 32'd0, "R5 R6 negative target");
    release_run(6);

    // E: stall for one cycle (R10)
    begin_scn(32'd0, 32'd0);
    put_word(0, W0); put_word(4, W1); put_word(8, HALT);
    expect_st(1, 32'd4, 5'b11100, 1'b0, 1'b1, W0, "R10 before stall");
    expect_st(2, 32'd4, 5'b11100, 1'b0, 1'b1, W0, "R10 held with bubble");
    expect_st(3, 32'd8, 5'b11000, 1'b0, 1'b1, W1, "R10 resumed");
    fork
      release_run(5);
      begin
        while (!(rst_n && cyc == 1)) @(negedge clk);
        #1 stall = 1'b1;
        @(negedge clk);
        #1 stall = 1'b0;
      end
    join

    finish_run();
  end
endmodule